// File: doc/BRIEF.md
# Latched Interrupt Aggregator

This block gathers single-cycle event pulses from many sources into groups of sticky event bits and turns them into one level-sensitive interrupt line for a host processor. Each group has its own event register, cleared by writing ones, and its own mask register. Masking only gates the interrupt; a masked event is still latched and can be read. One configuration register picks the active level of the interrupt and whether the pad is driven push-pull or as open-drain, the latter through an output-enable.

A pulse must never be lost to a race with the host's clear. While the host is reading an event register, pulses aimed at that register are held in a shadow register. While the power sequencer reports that it is changing state, pulses for all registers are held the same way. A held bit moves into its event register once nothing holds it and the matching event bit is clear. If the event bit is still set, the held bit waits until the host clears it and then shows up one cycle later. The host therefore sees the new event as a fresh interrupt and does not wipe it out with its own clear.

Top module: `irq_agg_top`

## Requirements
- R1: After synchronous reset every event, shadow and mask bit is 0 and the configuration is 0 (active-low, push-pull), so `irq_o` is 1 and `irq_oe` is 1.
- R2: An event pulse on bit `g*GRP_W+b` of `ev_in` with no hold active sets bit b of event register g (read address g). The bit reads 1 from the cycle after the pulse.
- R3: A write to event address g clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: Mask register g sits at address `NUM_GRP+g`. A mask bit of 1 keeps that event bit out of the interrupt, but a masked event is still latched and reads back as 1.
- R5: The interrupt is active while any unmasked event bit is set, and it stays active until all such bits are cleared.
- R6: Configuration bit 0 (address `2*NUM_GRP`) selects the polarity: with 0, `irq_o` is 0 when the interrupt is active; with 1, it is 1 when active.
- R7: Configuration bit 1 selects the drive. With 0 (push-pull), `irq_oe` is 1 and `irq_o` carries the level. With 1 (open-drain), `irq_o` is 0 and `irq_oe` is 1 only while the line level is low.
- R8: While `reg_rd` is high with `reg_addr` equal to g, pulses for group g go to the shadow and are not visible in event register g. Other groups latch as normal.
- R9: A shadow bit whose event bit is 0 and which is not held moves into the event register at the next edge. If the event bit is 1, the shadow bit waits: the clearing write makes the bit read 0 for one cycle, and the bit reads 1 again from the following cycle.
- R10: While `seq_busy` is high, pulses for every group go to the shadow. They merge one cycle after `seq_busy` falls.
- R11: A pulse that arrives in the same cycle as a clearing write to the same bit leaves that bit set.
- R12: The mask and configuration registers read back what was written (configuration in bits 1:0, other bits 0), and an unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | NUM_GRP*GRP_W | Single-cycle event pulses, group g in bits g*GRP_W upward |
| seq_busy | input | 1 | Power sequencer in transition; holds all incoming events |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | GRP_W | Write data |
| reg_rd | input | 1 | Read of `reg_addr` in progress |
| reg_rdata | output | GRP_W | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt pad data |
| irq_oe | output | 1 | Interrupt pad output-enable |

## Verification
The bench uses the default build of four groups of eight bits. This places the configuration register at address 8, with address 9 unmapped. With four groups, a read hold on one group can be checked against pulses landing in another group in the same cycle, and a masked group can be set alongside unmasked ones. The eight-bit width lets shadow and live event bits share one register, so the bench can check the one-cycle gap after a clear and check that a clear does not swallow an event arriving at the same time.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Configuration register layout (bit 0: polarity, bit 1: drive)
    typedef struct packed {
        logic drv_od;   // 1: open-drain, 0: push-pull
        logic pol_hi;   // 1: active-high, 0: active-low
    } irq_cfg_t;

    localparam int CFG_W = $bits(irq_cfg_t);

    // Line level seen at the pad for a given interrupt state
    function automatic logic line_level(input logic act, input irq_cfg_t c);
        return c.pol_hi ? act : ~act;
    endfunction

endpackage

// File: rtl/irq_agg_grp.sv
module irq_agg_grp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev,
    input  logic         hold,
    input  logic         clr_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] evt,
    output logic [W-1:0] mask,
    output logic         pend
);

    logic [W-1:0] shd;
    logic [W-1:0] clr, to_evt, to_shd, merge;

    always_comb begin
        clr    = clr_we ? wdata : '0;
        to_evt = hold ? '0 : ev;
        to_shd = hold ? ev : '0;
        merge  = hold ? '0 : (shd & ~evt & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt  <= '0;
            shd  <= '0;
            mask <= '0;
        end else begin
            evt <= (evt & ~clr) | to_evt | merge;
            shd <= (shd | to_shd) & ~merge;
            if (mask_we)
                mask <= wdata;
        end
    end

    assign pend = |(evt & ~mask);

    // R2 / R11: an unheld pulse is visible next cycle, even against a clear
    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (rst)
        (!hold && ev != '0) |=> ((evt & $past(ev)) == $past(ev)));

    // R8 / R10: nothing new appears in the event register while held
    a_r8_hold_no_new: assert property (@(posedge clk) disable iff (rst)
        hold |=> ((evt & ~$past(evt)) == '0));

    // R8: a held pulse is kept somewhere
    a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (hold && ev != '0) |=> (((shd | evt) & $past(ev)) == $past(ev)));

    // R9: an eligible shadow bit reaches the event register
    a_r9_merge: assert property (@(posedge clk) disable iff (rst)
        (!hold && (shd & ~evt & ~clr) != '0)
        |=> ((evt & $past(shd & ~evt & ~clr)) == $past(shd & ~evt & ~clr)));

    // R3: a clearing write with no source of new bits leaves the bit clear
    a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
        (clr_we && ev == '0 && shd == '0) |=> ((evt & $past(wdata)) == '0));

endmodule

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
    import irq_agg_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 8,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic [GRP_W-1:0]         reg_wdata,
    input  logic                     reg_rd,
    input  logic                     seq_busy,
    input  logic [NUM_GRP*GRP_W-1:0] evt_flat,
    input  logic [NUM_GRP*GRP_W-1:0] mask_flat,
    output logic [NUM_GRP-1:0]       clr_we,
    output logic [NUM_GRP-1:0]       mask_we,
    output logic [NUM_GRP-1:0]       hold,
    output irq_cfg_t                 cfg,
    output logic [GRP_W-1:0]         reg_rdata
);

    localparam int MASK_BASE = NUM_GRP;
    localparam int CFG_ADDR  = 2 * NUM_GRP;

    logic cfg_we;
    assign cfg_we = reg_wr && (reg_addr == ADDR_W'(CFG_ADDR));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
        assign clr_we[g]  = reg_wr && (reg_addr == ADDR_W'(g));
        assign mask_we[g] = reg_wr && (reg_addr == ADDR_W'(MASK_BASE + g));
        assign hold[g]    = seq_busy || (reg_rd && (reg_addr == ADDR_W'(g)));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (cfg_we)
            cfg <= irq_cfg_t'(reg_wdata[CFG_W-1:0]);
    end

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (reg_addr == ADDR_W'(g))
                reg_rdata = evt_flat[g*GRP_W +: GRP_W];
            if (reg_addr == ADDR_W'(MASK_BASE + g))
                reg_rdata = mask_flat[g*GRP_W +: GRP_W];
        end
        if (reg_addr == ADDR_W'(CFG_ADDR))
            reg_rdata = GRP_W'(cfg);
    end

    // R8: a read hold targets at most one group unless the sequencer holds all
    a_r8_one_read_hold: assert property (@(posedge clk) disable iff (rst)
        !seq_busy |-> $onehot0(hold));

    // R10: the sequencer holds every group
    a_r10_busy_all: assert property (@(posedge clk) disable iff (rst)
        seq_busy |-> (hold == {NUM_GRP{1'b1}}));

endmodule

// File: rtl/irq_agg_pad.sv
module irq_agg_pad
    import irq_agg_pkg::*;
(
    input  logic     act,
    input  irq_cfg_t cfg,
    output logic     pad_o,
    output logic     pad_oe
);

    logic lvl;

    always_comb begin
        lvl = line_level(act, cfg);
        if (cfg.drv_od) begin
            pad_o  = 1'b0;
            pad_oe = ~lvl;
        end else begin
            pad_o  = lvl;
            pad_oe = 1'b1;
        end
    end

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 8,
    parameter int ADDR_W  = $clog2(2 * NUM_GRP + 2)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_GRP*GRP_W-1:0] ev_in,
    input  logic                     seq_busy,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic [GRP_W-1:0]         reg_wdata,
    input  logic                     reg_rd,
    output logic [GRP_W-1:0]         reg_rdata,
    output logic                     irq_o,
    output logic                     irq_oe
);

    logic [NUM_GRP*GRP_W-1:0] evt_flat, mask_flat;
    logic [NUM_GRP-1:0]       clr_we, mask_we, hold, pend;
    irq_cfg_t                 cfg;
    logic                     irq_act;

    irq_agg_regif #(
        .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .ADDR_W(ADDR_W)
    ) u_regif (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .seq_busy(seq_busy),
        .evt_flat(evt_flat), .mask_flat(mask_flat),
        .clr_we(clr_we), .mask_we(mask_we), .hold(hold),
        .cfg(cfg), .reg_rdata(reg_rdata)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        irq_agg_grp #(.W(GRP_W)) u_grp (
            .clk(clk), .rst(rst),
            .ev(ev_in[g*GRP_W +: GRP_W]),
            .hold(hold[g]),
            .clr_we(clr_we[g]),
            .mask_we(mask_we[g]),
            .wdata(reg_wdata),
            .evt(evt_flat[g*GRP_W +: GRP_W]),
            .mask(mask_flat[g*GRP_W +: GRP_W]),
            .pend(pend[g])
        );
    end

    assign irq_act = |pend;

    irq_agg_pad u_pad (
        .act(irq_act), .cfg(cfg),
        .pad_o(irq_o), .pad_oe(irq_oe)
    );

    // R5: the interrupt is a level; only a register write can drop it
    a_r5_level_held: assert property (@(posedge clk) disable iff (rst)
        (irq_act && !reg_wr) |=> irq_act);

    // R7: push-pull always drives the pad
    a_r7_pp_drives: assert property (@(posedge clk) disable iff (rst)
        !cfg.drv_od |-> irq_oe);

    // R7: open-drain never drives high
    a_r7_od_low_only: assert property (@(posedge clk) disable iff (rst)
        (cfg.drv_od && irq_oe) |-> !irq_o);

endmodule

// File: tb/sim_irq_agg_top.sv
module sim_irq_agg_top;

    localparam int NG = 4;
    localparam int GW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NG*GW-1:0] ev_in;
    logic          seq_busy;
    logic [AW-1:0] reg_addr;
    logic          reg_wr;
    logic [GW-1:0] reg_wdata;
    logic          reg_rd;
    logic [GW-1:0] reg_rdata;
    logic          irq_o, irq_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_agg_top #(.NUM_GRP(NG), .GRP_W(GW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .ev_in(ev_in), .seq_busy(seq_busy),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .irq_oe(irq_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [GW-1:0] v);
        reg_addr = AW'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [GW-1:0] d);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        step();
        reg_wr    = 1'b0;
    endtask

    task automatic pulse(input int g, input int b);
        ev_in = '0;
        ev_in[g*GW+b] = 1'b1;
        step();
        ev_in = '0;
    endtask

    task automatic t_reset();
        logic [GW-1:0] v;
        rst = 1'b1; ev_in = '0; seq_busy = 0; reg_addr = '0;
        reg_wr = 0; reg_wdata = '0; reg_rd = 0;
        step(); step();
        rst = 1'b0;
        step();
        for (int a = 0; a < 2*NG+1; a++) begin
            rd(a, v);
            chk("R1 reg clear", 32'(v), 0);
        end
        chk("R1 irq_o idle", 32'(irq_o), 1);
        chk("R1 irq_oe", 32'(irq_oe), 1);
    endtask

    task automatic t_set_clear();
        logic [GW-1:0] v;
        pulse(1, 4);
        rd(1, v);
        chk("R2 event latched", 32'(v), 32'h10);
        chk("R5 irq active low", 32'(irq_o), 0);
        pulse(1, 0);
        wr(1, 8'h01);
        rd(1, v);
        chk("R3 w1c partial", 32'(v), 32'h10);
        chk("R5 still active", 32'(irq_o), 0);
        wr(1, 8'h10);
        rd(1, v);
        chk("R3 w1c all", 32'(v), 0);
        chk("R5 released", 32'(irq_o), 1);
    endtask

    task automatic t_mask();
        logic [GW-1:0] v;
        wr(NG+3, 8'hFF);
        rd(NG+3, v);
        chk("R12 mask readback", 32'(v), 32'hFF);
        pulse(3, 7);
        rd(3, v);
        chk("R4 masked still latched", 32'(v), 32'h80);
        chk("R4 masked no irq", 32'(irq_o), 1);
        wr(NG+3, 8'h7F);
        chk("R4 unmask raises irq", 32'(irq_o), 0);
        wr(3, 8'h80);
        chk("R4 cleared", 32'(irq_o), 1);
        wr(NG+3, 8'h00);
    endtask

    task automatic t_cfg();
        logic [GW-1:0] v;
        wr(2*NG, 8'hFD);
        rd(2*NG, v);
        chk("R12 cfg readback", 32'(v), 32'h01);
        rd(2*NG+1, v);
        chk("R12 unmapped", 32'(v), 0);
        chk("R6 active-high idle", 32'(irq_o), 0);
        pulse(0, 6);
        chk("R6 active-high asserted", 32'(irq_o), 1);
        wr(2*NG, 8'h03);
        chk("R7 od active-high asserted o", 32'(irq_o), 0);
        chk("R7 od active-high asserted oe", 32'(irq_oe), 0);
        wr(2*NG, 8'h02);
        chk("R7 od active-low asserted oe", 32'(irq_oe), 1);
        wr(0, 8'h40);
        chk("R7 od active-low idle oe", 32'(irq_oe), 0);
        chk("R7 od o low", 32'(irq_o), 0);
        wr(2*NG, 8'h00);
        chk("R7 pp oe", 32'(irq_oe), 1);
    endtask

    task automatic t_read_hold();
        logic [GW-1:0] v;
        pulse(0, 2);
        reg_addr = 0; reg_rd = 1'b1;
        ev_in = '0;
        ev_in[2] = 1'b1;       // group 0 bit 2, already set
        ev_in[5] = 1'b1;       // group 0 bit 5, clear
        ev_in[GW+1] = 1'b1;    // group 1 bit 1, not held
        step();
        ev_in = '0;
        #1;
        chk("R8 held not visible", 32'(reg_rdata), 32'h04);
        rd(1, v);
        chk("R8 other group latched", 32'(v), 32'h02);
        reg_addr = 0;
        reg_rd = 1'b0;
        step();
        rd(0, v);
        chk("R9 free shadow merges", 32'(v), 32'h24);
        wr(0, 8'h04);
        rd(0, v);
        chk("R9 gap after clear", 32'(v), 32'h20);
        step();
        rd(0, v);
        chk("R9 pending shadow merged", 32'(v), 32'h24);
        wr(0, 8'h24);
        rd(0, v);
        chk("R9 no stale shadow", 32'(v), 0);
        wr(1, 8'hFF);
    endtask

    task automatic t_busy();
        logic [GW-1:0] v;
        seq_busy = 1'b1;
        pulse(2, 0);
        pulse(3, 3);
        rd(2, v);
        chk("R10 held during busy", 32'(v), 0);
        chk("R10 no irq during busy", 32'(irq_o), 1);
        seq_busy = 1'b0;
        step();
        rd(2, v);
        chk("R10 merged g2", 32'(v), 32'h01);
        rd(3, v);
        chk("R10 merged g3", 32'(v), 32'h08);
        wr(2, 8'hFF);
        wr(3, 8'hFF);
    endtask

    task automatic t_race();
        logic [GW-1:0] v;
        pulse(1, 3);
        reg_addr = 1; reg_wdata = 8'h08; reg_wr = 1'b1;
        ev_in = '0; ev_in[GW+3] = 1'b1;
        step();
        reg_wr = 1'b0; ev_in = '0;
        rd(1, v);
        chk("R11 set beats clear", 32'(v), 32'h08);
        wr(1, 8'h08);
        rd(1, v);
        chk("R11 cleared after", 32'(v), 0);
        chk("R5 all clear idle", 32'(irq_o), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_set_clear();
        t_mask();
        t_cfg();
        t_read_hold();
        t_busy();
        t_race();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule